// File: doc/BRIEF.md
# DRAM Row Boundary Address Decoder

This block decides which of eight DRAM rows a physical address falls into. Software programs one 8-bit boundary value per row. Each value gives the top of that row in 8 MB units. The boundaries are cumulative, so a row starts where the last populated row below it ends. A lookup is presented with a valid strobe. One clock later the block returns whether the address hit a populated row and, if it did, which row.

A row whose boundary adds nothing above the running top is empty and is never selected. This covers both an equal boundary and a non-monotonic one that lies below the running top. A zero boundary that follows a populated row stands for the 2 GB ceiling. A separate inspection index shows the computed base and size of any row, so the decoded memory map can be read back without issuing lookups.

Top module: `dram_row_decoder`

## Requirements
- R1: After reset every boundary is zero, `res_valid` is low, every row reports base 0 and size 0, and every lookup misses.
- R2: A write with `cfg_we` high stores `cfg_wdata` into boundary `cfg_idx` (0..7). A lookup presented in the same cycle as the write still decodes with the old value. Lookups from the next cycle on use the new value.
- R3: The running top starts at 0. Row i's candidate limit is its boundary value shifted left by 23 bits. Row i's base is the running top left by the populated rows below it.
- R4: A lookup hits row i when row i is populated and base <= address < limit. The result is `res_hit` = 1 and `res_row` = i. If more than one row matches, the lowest index is reported.
- R5: A row whose candidate limit equals its base is empty. It is never selected, its size reads 0, and it leaves the running top unchanged.
- R6: A boundary of zero whose base is nonzero gives a candidate limit of 2^31 (2 GB).
- R7: A row whose candidate limit is below its base is treated as empty, and the running top keeps its previous value.
- R8: An address at or above the top of the highest populated row, or any address when no row is populated, gives `res_hit` = 0 with `res_row` = 0.
- R9: `res_valid` is high exactly one cycle after `lkp_valid` was high. Lookups may be issued back to back, and each result belongs to the lookup one cycle earlier.
- R10: `insp_base` and `insp_size` show, in the same cycle and without a clock edge, the base and the limit-minus-base of row `insp_idx` for the current boundaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Boundary write strobe |
| cfg_idx | input | 3 | Row whose boundary is written |
| cfg_wdata | input | 8 | Boundary value in 8 MB units |
| lkp_valid | input | 1 | Lookup request |
| lkp_addr | input | 32 | Physical address to decode |
| res_valid | output | 1 | Result valid, one cycle after the request |
| res_hit | output | 1 | Address lies in a populated row |
| res_row | output | 3 | Selected row, 0 on a miss |
| insp_idx | input | 3 | Row selected for inspection |
| insp_base | output | 32 | Base address of the inspected row |
| insp_size | output | 32 | Size in bytes of the inspected row |

## Verification
Lookup results are due exactly one clock edge after the request. The bench drives each request on a falling edge and samples the result on the following falling edge, which lies after the single registering edge. The inspection outputs are combinational from the boundary registers, so they are compared on the falling edge after a write has settled. For the write-ordering rule, a write and a lookup are placed in the same cycle, and the bench expects the pre-write decode in that lookup's result and the post-write decode in the next lookup's result. Each programmed map is swept at both ends of every 8 MB unit up to and past 2 GB.

// File: rtl/rowdec_pkg.sv
package rowdec_pkg;

  // Classification of a row after boundary evaluation
  typedef enum logic [1:0] {
    ROW_EMPTY  = 2'd0,   // adds nothing above the running top
    ROW_SPAN   = 2'd1,   // populated, limit taken from its boundary
    ROW_TO_TOP = 2'd2    // populated, zero boundary read as the ceiling
  } row_kind_e;

endpackage

// File: rtl/rowdec_bound_regs.sv
module rowdec_bound_regs #(
  parameter int ROWS  = 8,
  parameter int BND_W = 8,
  parameter int IDX_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [BND_W-1:0] cfg_wdata,
  output logic [BND_W-1:0] bnd_q [ROWS]
);

  for (genvar g = 0; g < ROWS; g++) begin : g_row
    logic             wr_en;
    logic [BND_W-1:0] bnd_d;

    assign wr_en = cfg_we && (cfg_idx == IDX_W'(g));

    always_comb begin
      bnd_d = bnd_q[g];
      if (wr_en) bnd_d = cfg_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) bnd_q[g] <= '0;
      else        bnd_q[g] <= bnd_d;
    end
  end

endmodule

// File: rtl/rowdec_limit_chain.sv
module rowdec_limit_chain
  import rowdec_pkg::*;
#(
  parameter int ROWS       = 8,
  parameter int BND_W      = 8,
  parameter int UNIT_SHIFT = 23,
  parameter int LIM_W      = BND_W + UNIT_SHIFT + 1
) (
  input  logic [BND_W-1:0] bnd_q     [ROWS],
  output logic [LIM_W-1:0] row_base  [ROWS],
  output logic [LIM_W-1:0] row_limit [ROWS],
  output logic [ROWS-1:0]  row_empty
);

  localparam logic [LIM_W-1:0] CEILING = LIM_W'(1) << (LIM_W - 1);

  row_kind_e        kind [ROWS];
  logic [LIM_W-1:0] cand [ROWS];

  // One ripple pass: the running top only ever grows
  always_comb begin
    logic [LIM_W-1:0] run_top;
    run_top = '0;
    for (int i = 0; i < ROWS; i++) begin
      row_base[i] = run_top;
      if ((bnd_q[i] == '0) && (run_top != '0)) begin
        cand[i] = CEILING;
      end else begin
        cand[i] = LIM_W'({bnd_q[i], {UNIT_SHIFT{1'b0}}});
      end
      if (cand[i] <= run_top)       kind[i] = ROW_EMPTY;
      else if (bnd_q[i] == '0)      kind[i] = ROW_TO_TOP;
      else                          kind[i] = ROW_SPAN;
      if (kind[i] == ROW_EMPTY) begin
        row_limit[i] = run_top;
        row_empty[i] = 1'b1;
      end else begin
        row_limit[i] = cand[i];
        row_empty[i] = 1'b0;
      end
      run_top = row_limit[i];
    end
  end

endmodule

// File: rtl/rowdec_lookup.sv
module rowdec_lookup #(
  parameter int ROWS   = 8,
  parameter int ADDR_W = 32,
  parameter int LIM_W  = 32,
  parameter int IDX_W  = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lkp_valid,
  input  logic [ADDR_W-1:0] lkp_addr,
  input  logic [LIM_W-1:0]  row_base  [ROWS],
  input  logic [LIM_W-1:0]  row_limit [ROWS],
  input  logic [ROWS-1:0]   row_empty,
  output logic              res_valid,
  output logic              res_hit,
  output logic [IDX_W-1:0]  res_row
);

  localparam int CMP_W = (ADDR_W > LIM_W) ? ADDR_W : LIM_W;

  logic [CMP_W-1:0] addr_x;
  logic [ROWS-1:0]  match;
  logic             hit_d;
  logic [IDX_W-1:0] row_d;
  logic             valid_nx;
  logic             hit_nx;
  logic [IDX_W-1:0] row_nx;

  assign addr_x = CMP_W'(lkp_addr);

  for (genvar g = 0; g < ROWS; g++) begin : g_cmp
    logic [CMP_W-1:0] base_x;
    logic [CMP_W-1:0] lim_x;
    assign base_x   = CMP_W'(row_base[g]);
    assign lim_x    = CMP_W'(row_limit[g]);
    assign match[g] = !row_empty[g] && (addr_x >= base_x) && (addr_x < lim_x);
  end

  // Lowest matching index wins
  always_comb begin
    hit_d = |match;
    row_d = '0;
    for (int i = ROWS - 1; i >= 0; i--) begin
      if (match[i]) row_d = IDX_W'(i);
    end
  end

  always_comb begin
    valid_nx = lkp_valid;
    hit_nx   = res_hit;
    row_nx   = res_row;
    if (lkp_valid) begin
      hit_nx = hit_d;
      row_nx = row_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_valid <= 1'b0;
      res_hit   <= 1'b0;
      res_row   <= '0;
    end else begin
      res_valid <= valid_nx;
      res_hit   <= hit_nx;
      res_row   <= row_nx;
    end
  end

endmodule

// File: rtl/dram_row_decoder.sv
module dram_row_decoder #(
  parameter int ROWS       = 8,
  parameter int BND_W      = 8,
  parameter int UNIT_SHIFT = 23,
  parameter int ADDR_W     = 32
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        cfg_we,
  input  logic [$clog2(ROWS)-1:0]     cfg_idx,
  input  logic [BND_W-1:0]            cfg_wdata,
  input  logic                        lkp_valid,
  input  logic [ADDR_W-1:0]           lkp_addr,
  output logic                        res_valid,
  output logic                        res_hit,
  output logic [$clog2(ROWS)-1:0]     res_row,
  input  logic [$clog2(ROWS)-1:0]     insp_idx,
  output logic [BND_W+UNIT_SHIFT:0]   insp_base,
  output logic [BND_W+UNIT_SHIFT:0]   insp_size
);

  localparam int IDX_W = $clog2(ROWS);
  localparam int LIM_W = BND_W + UNIT_SHIFT + 1;

  logic [BND_W-1:0] bnd_q     [ROWS];
  logic [LIM_W-1:0] row_base  [ROWS];
  logic [LIM_W-1:0] row_limit [ROWS];
  logic [ROWS-1:0]  row_empty;

  rowdec_bound_regs #(
    .ROWS (ROWS),
    .BND_W(BND_W),
    .IDX_W(IDX_W)
  ) u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_we   (cfg_we),
    .cfg_idx  (cfg_idx),
    .cfg_wdata(cfg_wdata),
    .bnd_q    (bnd_q)
  );

  rowdec_limit_chain #(
    .ROWS      (ROWS),
    .BND_W     (BND_W),
    .UNIT_SHIFT(UNIT_SHIFT),
    .LIM_W     (LIM_W)
  ) u_chain (
    .bnd_q    (bnd_q),
    .row_base (row_base),
    .row_limit(row_limit),
    .row_empty(row_empty)
  );

  rowdec_lookup #(
    .ROWS  (ROWS),
    .ADDR_W(ADDR_W),
    .LIM_W (LIM_W),
    .IDX_W (IDX_W)
  ) u_lookup (
    .clk      (clk),
    .rst_n    (rst_n),
    .lkp_valid(lkp_valid),
    .lkp_addr (lkp_addr),
    .row_base (row_base),
    .row_limit(row_limit),
    .row_empty(row_empty),
    .res_valid(res_valid),
    .res_hit  (res_hit),
    .res_row  (res_row)
  );

  // Empty rows have limit == base, so their size reads zero
  assign insp_base = row_base[insp_idx];
  assign insp_size = row_limit[insp_idx] - row_base[insp_idx];

endmodule

// File: rtl/rowdec_checker.sv
module rowdec_checker #(
  parameter int ROWS   = 8,
  parameter int BND_W  = 8,
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic [IDX_W-1:0] cfg_idx,
  input logic [BND_W-1:0] cfg_wdata,
  input logic             lkp_valid,
  input logic             res_valid,
  input logic             res_hit,
  input logic [IDX_W-1:0] res_row,
  input logic [BND_W-1:0] bnd_q [ROWS],
  input logic [ROWS-1:0]  row_empty
);

  assert_write_lands_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we |=> bnd_q[$past(cfg_idx)] == $past(cfg_wdata));

  assert_empty_never_hit_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && res_hit) |-> (($past(row_empty) & (ROWS'(1) << res_row)) == '0));

  assert_miss_row_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !res_hit |-> (res_row == '0));

  assert_result_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
    lkp_valid |=> res_valid);

  assert_no_spurious_result_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !lkp_valid |=> !res_valid);

endmodule

bind dram_row_decoder rowdec_checker #(
  .ROWS  (ROWS),
  .BND_W (BND_W),
  .ADDR_W(ADDR_W),
  .IDX_W ($clog2(ROWS))
) u_rowdec_checker (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_we   (cfg_we),
  .cfg_idx  (cfg_idx),
  .cfg_wdata(cfg_wdata),
  .lkp_valid(lkp_valid),
  .res_valid(res_valid),
  .res_hit  (res_hit),
  .res_row  (res_row),
  .bnd_q    (bnd_q),
  .row_empty(row_empty)
);

// File: tb/dram_row_decoder_bench.sv
module dram_row_decoder_bench;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_we;
  logic [2:0]  cfg_idx;
  logic [7:0]  cfg_wdata;
  logic        lkp_valid;
  logic [31:0] lkp_addr;
  logic        res_valid;
  logic        res_hit;
  logic [2:0]  res_row;
  logic [2:0]  insp_idx;
  logic [31:0] insp_base;
  logic [31:0] insp_size;

  int checks = 0;
  int errors = 0;
  logic [7:0] bnd_m [8];

  always #(CLK_PERIOD / 2) clk = ~clk;

  dram_row_decoder u_dram_row_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .lkp_valid(lkp_valid), .lkp_addr(lkp_addr),
    .res_valid(res_valid), .res_hit(res_hit), .res_row(res_row),
    .insp_idx(insp_idx), .insp_base(insp_base), .insp_size(insp_size)
  );

  // Expected map from the requirements: running top, 8 MB units, 2 GB ceiling
  function automatic void model_row(input int j, output logic [32:0] b,
                                    output logic [32:0] sz, output logic pop);
    logic [32:0] run, lim;
    run = '0; b = '0; sz = '0; pop = 1'b0;
    for (int i = 0; i < 8; i++) begin
      lim = {2'b0, bnd_m[i], 23'd0};
      if (bnd_m[i] == 8'd0 && run != 0) lim = 33'h0_8000_0000;
      if (i == j) begin
        b = run;
        pop = lim > run;
        sz = pop ? lim - run : 33'd0;
      end
      if (lim > run) run = lim;
    end
  endfunction

  function automatic void model_lookup(input logic [31:0] a, output logic h,
                                       output logic [2:0] r);
    logic [32:0] b, sz;
    logic pop;
    h = 1'b0; r = 3'd0;
    for (int i = 0; i < 8; i++) begin
      model_row(i, b, sz, pop);
      if (!h && pop && {1'b0, a} >= b && {1'b0, a} < b + sz) begin
        h = 1'b1; r = 3'(i);
      end
    end
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic write_bnd(input int idx, input logic [7:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'(idx); cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
    bnd_m[idx] = val;
  endtask

  task automatic program_map(input logic [7:0] v0, v1, v2, v3, v4, v5, v6, v7);
    write_bnd(0, v0); write_bnd(1, v1); write_bnd(2, v2); write_bnd(3, v3);
    write_bnd(4, v4); write_bnd(5, v5); write_bnd(6, v6); write_bnd(7, v7);
  endtask

  // Drive on a falling edge, sample on the next falling edge (one register)
  task automatic lookup(input logic [31:0] a, input string req);
    logic h; logic [2:0] r;
    model_lookup(a, h, r);
    @(negedge clk);
    lkp_valid = 1'b1; lkp_addr = a;
    @(negedge clk);
    lkp_valid = 1'b0;
    check(res_valid == 1'b1, "R9", "res_valid", 64'(res_valid), 64'd1);
    check(res_hit == h, req, $sformatf("hit @%h", a), 64'(res_hit), 64'(h));
    check(res_row == r, req, $sformatf("row @%h", a), 64'(res_row), 64'(r));
  endtask

  task automatic inspect_all(input string req);
    logic [32:0] b, sz; logic pop;
    for (int i = 0; i < 8; i++) begin
      model_row(i, b, sz, pop);
      insp_idx = 3'(i);
      #1;
      check(insp_base == b[31:0], req, $sformatf("base row %0d", i), 64'(insp_base), 64'(b));
      check(insp_size == sz[31:0], req, $sformatf("size row %0d", i), 64'(insp_size), 64'(sz));
    end
  endtask

  task automatic sweep(input string req);
    logic [32:0] u;
    for (int k = 0; k <= 256; k++) begin
      u = 33'(k) << 23;
      lookup(u[31:0], req);
      if (k > 0) lookup(u[31:0] - 32'd1, req);
    end
    lookup(32'hFFFF_FFFF, "R8");
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic h; logic [2:0] r;
    for (int i = 0; i < 8; i++) bnd_m[i] = 8'd0;
    rst_n = 1'b0; cfg_we = 1'b0; cfg_idx = '0; cfg_wdata = '0;
    lkp_valid = 1'b0; lkp_addr = '0; insp_idx = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check(res_valid == 1'b0, "R1", "res_valid after reset", 64'(res_valid), 64'd0);
    inspect_all("R1");
    lookup(32'h0000_0000, "R1");
    lookup(32'h0123_4567, "R1");

    // R3 R4 R5 R8: monotonic map with two empty rows
    program_map(8'd4, 8'd4, 8'd12, 8'd20, 8'd20, 8'd64, 8'd128, 8'd255);
    inspect_all("R3");
    sweep("R4");

    // R6: zero after a populated row reaches 2 GB, later zeros are empty
    program_map(8'd16, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0, 8'd0);
    inspect_all("R6");
    sweep("R6");

    // R7: non-monotonic boundaries, then a 2 GB ceiling row
    program_map(8'd32, 8'd16, 8'd48, 8'd8, 8'd0, 8'd0, 8'd200, 8'd0);
    inspect_all("R7");
    sweep("R7");

    // R5: leading empty rows, first populated row starts at zero
    program_map(8'd0, 8'd0, 8'd8, 8'd8, 8'd8, 8'd8, 8'd8, 8'd8);
    inspect_all("R5");
    sweep("R5");

    // R2: write and lookup in the same cycle use the old value
    program_map(8'd4, 8'd4, 8'd12, 8'd20, 8'd20, 8'd64, 8'd128, 8'd255);
    model_lookup(32'd5 << 23, h, r);
    @(negedge clk);
    cfg_we = 1'b1; cfg_idx = 3'd0; cfg_wdata = 8'd8;
    lkp_valid = 1'b1; lkp_addr = 32'd5 << 23;
    @(negedge clk);
    cfg_we = 1'b0;
    check(res_hit == h && res_row == r, "R2", "same-cycle lookup sees old map",
          64'(res_row), 64'(r));
    bnd_m[0] = 8'd8;
    model_lookup(32'd5 << 23, h, r);
    @(negedge clk);
    lkp_valid = 1'b0;
    check(res_hit == h && res_row == r, "R2", "next lookup sees new map",
          64'(res_row), 64'(r));
    check(r == 3'd0, "R2", "expected row after write", 64'(r), 64'd0);

    // R9: back-to-back lookups, then idle
    @(negedge clk);
    lkp_valid = 1'b1; lkp_addr = 32'd9 << 23;
    @(negedge clk);
    model_lookup(32'd9 << 23, h, r);
    check(res_valid && res_row == r && res_hit == h, "R9", "first of pair",
          64'(res_row), 64'(r));
    lkp_addr = 32'd100 << 23;
    @(negedge clk);
    lkp_valid = 1'b0;
    model_lookup(32'd100 << 23, h, r);
    check(res_valid && res_row == r && res_hit == h, "R9", "second of pair",
          64'(res_row), 64'(r));
    @(negedge clk);
    check(res_valid == 1'b0, "R9", "res_valid after idle", 64'(res_valid), 64'd0);

    // R10: inspection follows a write without a lookup
    write_bnd(7, 8'd0);
    inspect_all("R10");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule